// File: doc/BRIEF.md
# Search-Engine Write Command Sequencer

This block sits on the device side of a wide-word search coprocessor. It watches the host command bus (a 10-bit command field qualified by a valid strobe) and the 68-bit DQ bus, and turns host WRITE commands into one-cycle internal write strobes. Each strobe carries a target space, an address, the 68-bit data word and the index of the global mask register that the array logic will apply. The arrays themselves and the masking logic are outside the block.

A write starts with two command phases on consecutive clocks, 1A and 1B. The data phase follows: one data word for a single write, or n consecutive words for a burst. One mandatory idle clock then closes the operation. The device takes part only when the ID field of DQ names it, or when that field is all ones (broadcast).

Bursts take their addresses from an internal burst address register rather than from DQ. The host loads this register, together with a length, by writing the burst setup register in the register space. It then advances by one for every word written, and it keeps its value from one burst to the next.

Top module: `wsrch_wr_seq`

## Requirements
- R1: After reset, wr_en, busy and proto_err are 0, and wr_space, wr_addr, wr_data and gmask_idx are 0.
- R2: A single write is accepted under four conditions. In phase 1A, cmd_vld=1, cmd[1:0]=01, cmd[2]=0 and cmd[9]=0. In phase 1B, on the next clock, cmd_vld=1, cmd[1:0]=01, and cmd[8:3] equals its 1A value. The next clock is the data phase, and in the clock after it wr_en is 1 for exactly one cycle. With that pulse come wr_data equal to the data-phase DQ and gmask_idx equal to cmd[5:3].
- R3: The ID field is DQ[25:21], sampled in phase 1B. The command proceeds only if this field equals dev_id or equals 5'b11111. On any other value, the block goes idle after 1B without writing and without flagging an error.
- R4: The space field is DQ[20:19], sampled in phase 1B. 00 selects the data array and 01 the mask array; for both, wr_addr takes DQ[14:0]. 11 selects the register space, where wr_addr is DQ[5:0] zero-extended. 10 is rejected: proto_err pulses and nothing is written.
- R5: If phase 1B has cmd_vld=0, an opcode other than 01, or cmd[8:3] that differs from 1A, proto_err pulses in the cycle after 1B. Nothing is written, and the block returns to idle.
- R6: While idle, the block ignores any cycle that has cmd_vld=0, an opcode other than 01, or cmd[9]=1. In those cases busy and proto_err both stay 0.
- R7: busy is 1 from the cycle after phase 1A through the closing idle clock, and wr_en is only ever 1 while busy is 1. A WRITE opcode with cmd_vld=1 during the closing idle clock pulses proto_err. That command is discarded, and busy is 0 on the next cycle.
- R8: A single register-space write to register address 6'h30 loads the burst setup. The burst address register takes DQ[14:0] as the start address, and the length is set from DQ[22:15].
- R9: A burst has cmd[2]=1 in phase 1A. After 1B come n data words on consecutive clocks, where n is the programmed length and a length of 0 counts as 1. Each word produces a wr_en pulse one clock later, at the burst address register value, which then increments. The closing idle clock follows the last word.
- R10: Between bursts, the burst address register keeps its incremented value. A second burst with no new setup write continues at start+n.
- R11: A burst aimed at space 11 or 10 pulses proto_err in the cycle after 1B, and nothing is written.
- R12: During data words, a WRITE opcode with cmd_vld=1 pulses proto_err. That command is discarded, and the burst goes on with unchanged addresses.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | This device's ID |
| cmd_vld | input | 1 | Command valid strobe |
| cmd | input | 10 | Command field: opcode [1:0], burst [2], mask index [5:3], upper field [8:6], special [9] |
| dq | input | 68 | Address in command phases, write data in data phases |
| wr_en | output | 1 | Internal write strobe, one cycle per word |
| wr_space | output | 2 | Target space of the write |
| wr_addr | output | 15 | Write address |
| wr_data | output | 68 | Write data |
| gmask_idx | output | 3 | Global mask register index |
| busy | output | 1 | A write sequence is in progress |
| proto_err | output | 1 | One-cycle pulse on a rejected or colliding command |

## Verification
The bench targets the places where the two command phases can disagree: a mask index that changes in 1B, a foreign ID compared with a broadcast, and a forbidden space. A design that latched fields from the wrong phase would write under the wrong mask or address, or would write for another device. It then probes the closing idle clock with a fresh command: a sequencer that skipped the idle clock would start that command instead of flagging it. Bursts are exercised with length 0, with a continuation that does not reload the setup, and with a colliding command in mid-burst. These cases expose an off-by-one word count, an address register reset between bursts, and a burst derailed by a stray strobe.

// File: rtl/wsrch_wr_seq.sv
`timescale 1ns/1ps
module wsrch_wr_seq #(
  parameter int DQ_W     = 68,
  parameter int ADDR_W   = 15,
  parameter int LEN_W    = 8,
  parameter int RADDR_W  = 6,
  parameter logic [5:0] BCFG_REG = 6'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        dev_id,
  input  logic              cmd_vld,
  input  logic [9:0]        cmd,
  input  logic [DQ_W-1:0]   dq,
  output logic              wr_en,
  output logic [1:0]        wr_space,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DQ_W-1:0]   wr_data,
  output logic [2:0]        gmask_idx,
  output logic              busy,
  output logic              proto_err
);

  localparam logic [4:0] BCAST  = 5'h1F;
  localparam logic [1:0] SP_REG = 2'b11;
  localparam logic [1:0] SP_BAD = 2'b10;
  localparam int         LEN_LO = ADDR_W;
  localparam int         LEN_HI = ADDR_W + LEN_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_PHB, S_DATA, S_GAP} st_t;

  st_t               st_q;
  logic              burst_q;
  logic [5:0]        fld_q;
  logic [1:0]        space_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [LEN_W-1:0]  blen_q;
  logic [LEN_W-1:0]  cnt_q;

  logic       is_wr, id_hit, is_bcfg;
  logic [1:0] sp_in;

  assign is_wr   = cmd_vld && (cmd[1:0] == 2'b01);
  assign id_hit  = (dq[25:21] == dev_id) || (dq[25:21] == BCAST);
  assign sp_in   = dq[20:19];
  assign is_bcfg = !burst_q && (space_q == SP_REG) &&
                   (addr_q == {{(ADDR_W-RADDR_W){1'b0}}, BCFG_REG[RADDR_W-1:0]});
  assign busy    = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      burst_q   <= 1'b0;
      fld_q     <= '0;
      space_q   <= '0;
      addr_q    <= '0;
      baddr_q   <= '0;
      blen_q    <= '0;
      cnt_q     <= '0;
      wr_en     <= 1'b0;
      wr_space  <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      gmask_idx <= '0;
      proto_err <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      proto_err <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (is_wr && !cmd[9]) begin
            st_q    <= S_PHB;
            burst_q <= cmd[2];
            fld_q   <= cmd[8:3];
          end
        end
        S_PHB: begin
          if (!is_wr || (cmd[8:3] != fld_q)) begin
            proto_err <= 1'b1;
            st_q      <= S_IDLE;
          end else if (!id_hit) begin
            st_q <= S_IDLE;
          end else if ((sp_in == SP_BAD) || (burst_q && (sp_in == SP_REG))) begin
            proto_err <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            st_q    <= S_DATA;
            space_q <= sp_in;
            addr_q  <= (sp_in == SP_REG) ? {{(ADDR_W-RADDR_W){1'b0}}, dq[RADDR_W-1:0]}
                                         : dq[ADDR_W-1:0];
            cnt_q   <= !burst_q ? LEN_W'(1) : ((blen_q == '0) ? LEN_W'(1) : blen_q);
          end
        end
        S_DATA: begin
          if (is_wr) proto_err <= 1'b1;
          wr_en     <= 1'b1;
          wr_space  <= space_q;
          wr_data   <= dq;
          gmask_idx <= fld_q[2:0];
          wr_addr   <= burst_q ? baddr_q : addr_q;
          if (burst_q) baddr_q <= baddr_q + 1'b1;
          if (is_bcfg) begin
            baddr_q <= dq[ADDR_W-1:0];
            blen_q  <= dq[LEN_HI:LEN_LO];
          end
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) st_q <= S_GAP;
        end
        default: begin
          if (is_wr) proto_err <= 1'b1;
          st_q <= S_IDLE;
        end
      endcase
    end
  end

  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R7
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_GAP) |=> (st_q == S_IDLE)); // R7
  AST_NO_BAD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_space != SP_BAD)); // R4
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R9
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> ($stable(gmask_idx) && $stable(wr_space))); // R5
  AST_REG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_space == SP_REG) |-> !$past(wr_en)); // R11

endmodule

// File: tb/wsrch_wr_seq_bench.sv
`timescale 1ns/1ps
module wsrch_wr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dev_id = 5'h05;
  logic        cmd_vld = 1'b0;
  logic [9:0]  cmd = '0;
  logic [67:0] dq = '0;
  logic        wr_en, busy, proto_err;
  logic [1:0]  wr_space;
  logic [14:0] wr_addr;
  logic [67:0] wr_data;
  logic [2:0]  gmask_idx;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wsrch_wr_seq u_wsrch_wr_seq (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
    .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .gmask_idx(gmask_idx), .busy(busy), .proto_err(proto_err));

  task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [9:0] c, input logic [67:0] d);
    cmd_vld = v; cmd = c; dq = d;
    @(negedge clk);
  endtask

  function automatic logic [9:0] wcmd(input logic b, input logic [2:0] idx);
    return {4'b0000, idx, b, 2'b01};
  endfunction

  function automatic logic [67:0] hdr(input logic [4:0] id, input logic [1:0] sp, input logic [14:0] a);
    logic [67:0] h = '0;
    h[25:21] = id; h[20:19] = sp; h[14:0] = a;
    return h;
  endfunction

  task automatic single(input logic [4:0] id, input logic [1:0] sp, input logic [14:0] a,
                        input logic [2:0] idx, input logic [67:0] d);
    cyc(1, wcmd(0, idx), hdr(id, sp, a));
    cyc(1, wcmd(0, idx), hdr(id, sp, a));
    cyc(0, '0, d);
  endtask

  task automatic setup_burst(input logic [14:0] start, input logic [7:0] len);
    logic [67:0] d = '0;
    d[14:0] = start; d[22:15] = len;
    single(5'h05, 2'b11, 15'h0030, 3'd0, d);
    chk("R8 cfg write strobe", wr_en, 1);
    chk("R8 cfg write addr", wr_addr, 15'h0030);
    cyc(0, '0, '0);
  endtask

  task automatic t_reset;
    chk("R1 wr_en", wr_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 wr_data", wr_data, 0);
  endtask

  task automatic t_single;
    cyc(1, wcmd(0, 3'd5), hdr(5'h05, 2'b00, 15'h1234));
    chk("R7 busy after 1A", busy, 1);
    cyc(1, wcmd(0, 3'd5), hdr(5'h05, 2'b00, 15'h1234));
    chk("R2 no strobe before data", wr_en, 0);
    cyc(0, '0, 68'hA_BCDE_F012_3456_789A);
    chk("R2 strobe", wr_en, 1);
    chk("R2 data", wr_data, 68'hA_BCDE_F012_3456_789A);
    chk("R2 idx", gmask_idx, 3'd5);
    chk("R4 data space", wr_space, 2'b00);
    chk("R4 data addr", wr_addr, 15'h1234);
    chk("R7 busy in idle clock", busy, 1);
    cyc(0, '0, '0);
    chk("R2 one-cycle strobe", wr_en, 0);
    chk("R7 busy released", busy, 0);
  endtask

  task automatic t_mask_bcast_reg;
    single(5'h1F, 2'b01, 15'h7001, 3'd2, 68'h5);
    chk("R3 broadcast strobe", wr_en, 1);
    chk("R4 mask space", wr_space, 2'b01);
    chk("R4 mask addr", wr_addr, 15'h7001);
    cyc(0, '0, '0);
    single(5'h05, 2'b11, 15'h7C0A, 3'd1, 68'h77);
    chk("R4 reg space", wr_space, 2'b11);
    chk("R4 reg addr", wr_addr, 15'h000A);
    cyc(0, '0, '0);
  endtask

  task automatic t_id_miss;
    single(5'h06, 2'b00, 15'h0100, 3'd0, 68'h1);
    chk("R3 foreign id no write", wr_en, 0);
    chk("R3 foreign id no error", proto_err, 0);
    chk("R3 foreign id idle", busy, 0);
  endtask

  task automatic t_bad_space_idx;
    cyc(1, wcmd(0, 3'd0), hdr(5'h05, 2'b10, 15'h0));
    cyc(1, wcmd(0, 3'd0), hdr(5'h05, 2'b10, 15'h0));
    chk("R4 space 10 error", proto_err, 1);
    cyc(0, '0, 68'h9);
    chk("R4 space 10 no write", wr_en, 0);
    cyc(1, wcmd(0, 3'd3), hdr(5'h05, 2'b00, 15'h2));
    cyc(1, wcmd(0, 3'd4), hdr(5'h05, 2'b00, 15'h2));
    chk("R5 idx change error", proto_err, 1);
    chk("R5 idx change idle", busy, 0);
    cyc(0, '0, 68'h9);
    chk("R5 idx change no write", wr_en, 0);
  endtask

  task automatic t_ignore;
    cyc(1, 10'b00_0000_0010, hdr(5'h05, 2'b00, 15'h1));
    chk("R6 other opcode busy", busy, 0);
    chk("R6 other opcode err", proto_err, 0);
    cyc(1, 10'b10_0000_0001, hdr(5'h05, 2'b00, 15'h1));
    chk("R6 bit9 busy", busy, 0);
    cyc(0, wcmd(0, 3'd0), hdr(5'h05, 2'b00, 15'h1));
    chk("R6 strobe low busy", busy, 0);
    chk("R6 strobe low err", proto_err, 0);
  endtask

  task automatic t_gap_cmd;
    single(5'h05, 2'b00, 15'h0040, 3'd1, 68'h3);
    cyc(1, wcmd(0, 3'd1), hdr(5'h05, 2'b00, 15'h0041));
    chk("R7 gap command error", proto_err, 1);
    chk("R7 gap command discarded", busy, 0);
    cyc(0, '0, '0);
    chk("R7 gap command no write", wr_en, 0);
  endtask

  task automatic t_burst;
    setup_burst(15'h0100, 8'd3);
    cyc(1, wcmd(1, 3'd2), hdr(5'h05, 2'b00, 15'h0));
    cyc(1, wcmd(0, 3'd2), hdr(5'h05, 2'b00, 15'h0));
    for (int i = 0; i < 3; i++) begin
      cyc(0, '0, 68'(64'hD0 + i));
      chk("R9 burst strobe", wr_en, 1);
      chk("R9 burst addr", wr_addr, 15'h0100 + 15'(i));
      chk("R9 burst data", wr_data, 68'(64'hD0 + i));
      chk("R9 burst idx", gmask_idx, 3'd2);
    end
    cyc(0, '0, '0);
    chk("R9 burst ends", wr_en, 0);
    chk("R9 burst idle released", busy, 0);
    cyc(1, wcmd(1, 3'd6), hdr(5'h05, 2'b01, 15'h0));
    cyc(1, wcmd(0, 3'd6), hdr(5'h05, 2'b01, 15'h0));
    cyc(0, '0, 68'hE0);
    chk("R10 continue addr", wr_addr, 15'h0103);
    cyc(1, wcmd(0, 3'd0), 68'hE1);
    chk("R10 continue addr 2", wr_addr, 15'h0104);
    chk("R12 collision error", proto_err, 1);
    cyc(0, '0, 68'hE2);
    chk("R12 burst goes on", wr_addr, 15'h0105);
    chk("R12 data unaffected", wr_data, 68'hE2);
    cyc(0, '0, '0);
    chk("R9 burst done", busy, 0);
  endtask

  task automatic t_len0_regburst;
    setup_burst(15'h7FFF, 8'd0);
    cyc(1, wcmd(1, 3'd0), hdr(5'h05, 2'b00, 15'h0));
    cyc(1, wcmd(0, 3'd0), hdr(5'h05, 2'b00, 15'h0));
    cyc(0, '0, 68'hF);
    chk("R9 len0 one word", wr_addr, 15'h7FFF);
    chk("R9 len0 in idle clock", busy, 1);
    cyc(0, '0, '0);
    chk("R9 len0 single strobe", wr_en, 0);
    cyc(1, wcmd(1, 3'd0), hdr(5'h05, 2'b11, 15'h0));
    cyc(1, wcmd(0, 3'd0), hdr(5'h05, 2'b11, 15'h0));
    chk("R11 reg burst error", proto_err, 1);
    cyc(0, '0, 68'h1);
    chk("R11 reg burst no write", wr_en, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_mask_bcast_reg();
    t_id_miss();
    t_bad_space_idx();
    t_ignore();
    t_gap_cmd();
    t_burst();
    t_len0_regburst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule